// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus when a target device keeps SDA low, which happens when the target is still waiting to drive an acknowledge that it never got a clock for. A single-cycle request starts a fixed timed series of line operations on open-drain SCL and SDA. When the series ends, the block pulses `done_o` for one clock, and it pulses `err_o` together with `done_o` if a timed wait expired. The block does not carry out normal byte transfers. It only moves the bus back to a known idle state.

Two modes are selected at request time. The blind mode repeats a release / START / repeated-START frame nine times, with fixed gaps between frames, and then issues a STOP. The probing mode first tries a START and checks whether SDA was already low. That condition is an arbitration loss, and it marks the bus as stuck. If the bus is stuck, the block drops out, starts over, clocks one byte with SDA released and sends a STOP. If the bus is not stuck, it clocks one byte and sends a STOP. All hold times come from parameters given in microseconds, scaled by a clocks-per-microsecond parameter. The sensed lines pass through a synchronizer before the block uses them.

Top module: `i2c_unjam_seq`

## Requirements
- R1: After reset, and whenever `busy_o` is low, both pull outputs are 0 (released) and `done_o` and `err_o` are 0. A pull output of 1 means the block drives that line low.
- R2: In blind mode (`probe_mode_i`=0 at acceptance) each of the nine frames is made of the following steps, written as (scl_pull,sda_pull). First (0,0) for Q clocks. Then a START hold of (0,1) for HOLD_US*CLK_PER_US clocks. Then a repeated START of (1,1), (1,0), (0,0), (0,1) at Q clocks each. Q is QTR_CYC.
- R3: Frames one to eight stay at (0,1) for a further GAP_US*CLK_PER_US clocks after the repeated START. The ninth frame has no such gap.
- R4: Every successful run ends with a STOP of (1,1) then (0,1), Q clocks each. It then holds (0,0) for HOLD_US*CLK_PER_US clocks before the `done_o` cycle.
- R5: Probing mode starts with (0,0) for Q clocks and samples the synchronized SDA at the end. It then drives (0,1) until the synchronized SDA reads low, and holds (0,1) for Q more clocks.
- R6: If SDA was low at that sample, the block releases (0,0) for Q clocks and repeats the START-and-wait step once before it clocks the byte. The target is then free, and SDA reads high after the run.
- R7: The byte clocking is (1,1) for Q clocks, followed by nine pulses. Each pulse is (1,0) for 2Q clocks, then (0,0) until the synchronized SCL reads high, then (0,0) for 2Q more clocks. The byte ends with (1,0) for Q clocks, and the STOP of R4 follows.
- R8: A wait for SDA low or for SCL high that lasts TMO_US*CLK_PER_US clocks ends the run. Both lines are released and `done_o` and `err_o` pulse together.
- R9: A request is accepted only while idle, and the mode is taken at that moment. A request during a run, including its `done_o` cycle, has no effect.
- R10: `done_o` is high for exactly one clock per run, and `err_o` is never high without `done_o`.
- R11: In no clock edge do both pull outputs change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Recovery request, taken only while idle |
| probe_mode_i | input | 1 | 1 selects the probing mode, 0 the blind nine-frame mode |
| scl_in_i | input | 1 | Sensed SCL line level |
| sda_in_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 drives SDA low, 0 releases it |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-clock pulse at the end of a run |
| err_o | output | 1 | Pulses with `done_o` when a wait timed out |

## Verification
Each fault inside the block shows up at the pull outputs. It appears as a line state that holds for the wrong number of clocks, and it is visible at the very next change of either line. A wrong frame counter adds or removes a whole START/repeated-START pair before the STOP. A wrong arbitration flag adds or drops the extra release step within Q clocks after the first START hold. A wrong timeout decision changes both the length of the wait and the `err_o` value on the `done_o` cycle. The bench compares every run of identical line states, its length and how it ends against an independently built expected list.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;

    // Pull request on the two lines: 1 = drive low, 0 = release
    typedef struct packed {
        logic scl;
        logic sda;
    } pull_t;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_B_REL,     // blind: release both
        ST_B_START,   // blind: START hold
        ST_RS_A,      // repeated START quarter phases
        ST_RS_B,
        ST_RS_C,
        ST_RS_D,
        ST_B_GAP,     // blind: inter-frame gap
        ST_P_REL,     // probe: release and sample SDA
        ST_P_START,   // probe: START, wait for SDA low
        ST_P_HOLD,    // probe: START hold
        ST_S_OFF,     // stuck: drop out before re-arming
        ST_Y_DROP,    // byte: pull SCL under the START
        ST_Y_LOW,     // byte: clock low phase
        ST_Y_RISE,    // byte: wait for SCL high
        ST_Y_HIGH,    // byte: clock high phase
        ST_Y_TAIL,    // byte: final low phase before STOP
        ST_X_A,       // STOP: both low
        ST_X_B,       // STOP: SCL released, SDA low
        ST_SETTLE,    // lines released, let STOP settle
        ST_DONE
    } state_e;

    function automatic pull_t drive_of(state_e s);
        pull_t p;
        case (s)
            ST_B_START, ST_RS_D, ST_B_GAP,
            ST_P_START, ST_P_HOLD, ST_X_B: begin
                p.scl = 1'b0;
                p.sda = 1'b1;
            end
            ST_RS_A, ST_Y_DROP, ST_X_A: begin
                p.scl = 1'b1;
                p.sda = 1'b1;
            end
            ST_RS_B, ST_Y_LOW, ST_Y_TAIL: begin
                p.scl = 1'b1;
                p.sda = 1'b0;
            end
            default: begin
                p.scl = 1'b0;
                p.sda = 1'b0;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] chain [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) chain[i] <= '1;
                end else begin
                    chain[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
                end
            end
            assign q_o = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/unjam_timer.sv
module unjam_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/unjam_ctrl.sv
module unjam_ctrl
    import i2c_unjam_pkg::*;
#(
    parameter int QTR_CYC     = 250,
    parameter int HOLD_CYC    = 1500,
    parameter int GAP_CYC     = 500,
    parameter int TMO_CYC     = 10000,
    parameter int CYCLES      = 9,
    parameter int BYTE_CLOCKS = 9,
    parameter int TW          = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          probe_mode_i,
    input  logic          scl_s_i,
    input  logic          sda_s_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          scl_pull_o,
    output logic          sda_pull_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam int BW = $clog2(BYTE_CLOCKS + 1);
    localparam logic [CW-1:0] LAST_CYC = CW'(CYCLES - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_CLOCKS - 1);
    localparam logic [TW-1:0] V_Q    = TW'(QTR_CYC - 1);
    localparam logic [TW-1:0] V_2Q   = TW'(2 * QTR_CYC - 1);
    localparam logic [TW-1:0] V_HOLD = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] V_GAP  = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] V_TMO  = TW'(TMO_CYC - 1);

    state_e        state_q, state_d;
    logic [CW-1:0] cyc_q;
    logic [BW-1:0] bit_q;
    logic          arb_q, second_q, err_q;
    logic          tz, fail;
    pull_t         lines;

    assign tz = tmr_zero_i;

    assign fail = (state_q == ST_P_START && sda_s_i && tz) ||
                  (state_q == ST_Y_RISE && !scl_s_i && tz);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req_i) state_d = probe_mode_i ? ST_P_REL : ST_B_REL;
            ST_B_REL:   if (tz) state_d = ST_B_START;
            ST_B_START: if (tz) state_d = ST_RS_A;
            ST_RS_A:    if (tz) state_d = ST_RS_B;
            ST_RS_B:    if (tz) state_d = ST_RS_C;
            ST_RS_C:    if (tz) state_d = ST_RS_D;
            ST_RS_D:    if (tz) state_d = (cyc_q == LAST_CYC) ? ST_X_A : ST_B_GAP;
            ST_B_GAP:   if (tz) state_d = ST_B_REL;
            ST_P_REL:   if (tz) state_d = ST_P_START;
            ST_P_START: begin
                if (!sda_s_i)  state_d = ST_P_HOLD;
                else if (tz)   state_d = ST_DONE;
            end
            ST_P_HOLD:  if (tz) state_d = (arb_q && !second_q) ? ST_S_OFF : ST_Y_DROP;
            ST_S_OFF:   if (tz) state_d = ST_P_START;
            ST_Y_DROP:  if (tz) state_d = ST_Y_LOW;
            ST_Y_LOW:   if (tz) state_d = ST_Y_RISE;
            ST_Y_RISE: begin
                if (scl_s_i)   state_d = ST_Y_HIGH;
                else if (tz)   state_d = ST_DONE;
            end
            ST_Y_HIGH:  if (tz) state_d = (bit_q == LAST_BIT) ? ST_Y_TAIL : ST_Y_LOW;
            ST_Y_TAIL:  if (tz) state_d = ST_X_A;
            ST_X_A:     if (tz) state_d = ST_X_B;
            ST_X_B:     if (tz) state_d = ST_SETTLE;
            ST_SETTLE:  if (tz) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Duration of the state being entered, loaded on every state change
    always_comb begin
        case (state_d)
            ST_B_START, ST_SETTLE:            tmr_val_o = V_HOLD;
            ST_B_GAP:                         tmr_val_o = V_GAP;
            ST_P_START, ST_Y_RISE:            tmr_val_o = V_TMO;
            ST_Y_LOW, ST_Y_HIGH:              tmr_val_o = V_2Q;
            ST_IDLE, ST_DONE:                 tmr_val_o = '0;
            default:                          tmr_val_o = V_Q;
        endcase
    end
    assign tmr_load_o = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cyc_q    <= '0;
            bit_q    <= '0;
            arb_q    <= 1'b0;
            second_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_i) begin
                cyc_q    <= '0;
                bit_q    <= '0;
                arb_q    <= 1'b0;
                second_q <= 1'b0;
                err_q    <= 1'b0;
            end
            if (state_q == ST_B_GAP && tz) cyc_q <= cyc_q + CW'(1);
            if (state_q == ST_P_REL && tz) arb_q <= !sda_s_i;
            if (state_q == ST_P_HOLD && tz && arb_q && !second_q) second_q <= 1'b1;
            if (state_q == ST_Y_DROP) bit_q <= '0;
            if (state_q == ST_Y_HIGH && tz && bit_q != LAST_BIT) bit_q <= bit_q + BW'(1);
            if (fail) err_q <= 1'b1;
        end
    end

    assign lines      = drive_of(state_q);
    assign scl_pull_o = lines.scl;
    assign sda_pull_o = lines.sda;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_DONE);
    assign err_o      = (state_q == ST_DONE) && err_q;
endmodule

// File: rtl/i2c_unjam_seq.sv
module i2c_unjam_seq #(
    parameter int CLK_PER_US  = 100,
    parameter int QTR_CYC     = 250,
    parameter int SYNC_STAGES = 2,
    parameter int CYCLES      = 9,
    parameter int BYTE_CLOCKS = 9,
    parameter int HOLD_US     = 15,
    parameter int GAP_US      = 5,
    parameter int TMO_US      = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic probe_mode_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    localparam int HOLD_CYC = HOLD_US * CLK_PER_US;
    localparam int GAP_CYC  = GAP_US * CLK_PER_US;
    localparam int TMO_CYC  = TMO_US * CLK_PER_US;
    localparam int M1       = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int M2       = (TMO_CYC > 2 * QTR_CYC) ? TMO_CYC : 2 * QTR_CYC;
    localparam int MAXC     = (M1 > M2) ? M1 : M2;
    localparam int TW       = $clog2(MAXC + 1);

    logic [1:0]    sensed;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    unjam_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_in_i, sda_in_i}),
        .q_o (sensed)
    );

    unjam_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    unjam_ctrl #(
        .QTR_CYC     (QTR_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .GAP_CYC     (GAP_CYC),
        .TMO_CYC     (TMO_CYC),
        .CYCLES      (CYCLES),
        .BYTE_CLOCKS (BYTE_CLOCKS),
        .TW          (TW)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_i),
        .probe_mode_i (probe_mode_i),
        .scl_s_i      (sensed[1]),
        .sda_s_i      (sensed[0]),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );
endmodule

// File: rtl/i2c_unjam_chk.sv
module i2c_unjam_chk #(
    parameter int CYCLES = 9
) (
    input logic clk,
    input logic rst,
    input logic req_i,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic scl_pull_o,
    input logic sda_pull_o
);
    logic [15:0] starts_q;
    logic        prev_sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            starts_q   <= '0;
            prev_sda_q <= 1'b0;
        end else begin
            prev_sda_q <= sda_pull_o;
            if (!busy_o)
                starts_q <= '0;
            else if (sda_pull_o && !prev_sda_q && !scl_pull_o)
                starts_q <= starts_q + 16'd1;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_pull_o && !sda_pull_o && !done_o && !err_o)); // R1

    AST_START_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (starts_q <= 16'(2 * CYCLES))); // R2

    AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!scl_pull_o && !sda_pull_o)); // R8

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o); // R9

    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(req_i)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o); // R10

    AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        !(($past(scl_pull_o) != scl_pull_o) && ($past(sda_pull_o) != sda_pull_o))); // R11
endmodule

bind i2c_unjam_seq i2c_unjam_chk #(.CYCLES(CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o)
);

// File: tb/i2c_unjam_seq_test.sv
module i2c_unjam_seq_test;
    localparam int CPU = 4;
    localparam int Q   = 3;
    localparam int N   = 2;
    localparam int H   = 15 * CPU;
    localparam int G   = 5 * CPU;
    localparam int T   = 100 * CPU;
    localparam int NC  = 9;
    localparam int NB  = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic pmode = 1'b0;
    logic scl_in, sda_in, scl_pull, sda_pull, busy, done, err;

    // bus model: open drain with target faults
    logic slv_scl_hold = 1'b0;
    logic sda_force_hi = 1'b0;
    logic stuck_en = 1'b0;
    int   stuck_base = 0;
    int   stuck_len = 4;
    int   scl_rises = 0;
    logic slv_sda_hold;

    assign slv_sda_hold = stuck_en && ((scl_rises - stuck_base) < stuck_len);
    assign scl_in = ~scl_pull & ~slv_scl_hold;
    assign sda_in = sda_force_hi ? 1'b1 : (~sda_pull & ~slv_sda_hold);

    always @(posedge scl_in) scl_rises <= scl_rises + 1;

    always #2 clk = ~clk;

    i2c_unjam_seq #(.CLK_PER_US(CPU), .QTR_CYC(Q), .SYNC_STAGES(N)) uut (
        .clk (clk), .rst (rst), .req_i (req), .probe_mode_i (pmode),
        .scl_in_i (scl_in), .sda_in_i (sda_in),
        .scl_pull_o (scl_pull), .sda_pull_o (sda_pull),
        .busy_o (busy), .done_o (done), .err_o (err)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int done_cnt = 0;

    typedef struct packed {
        bit        scl;
        bit        sda;
        bit        last;
        bit        err;
        bit [31:0] len;
        bit [23:0] tag;
    } seg_t;

    seg_t expq[$];
    seg_t pend;
    bit   pend_v = 0;

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic check(bit ok, input bit [23:0] tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // driver side: build merged expected segments
    task automatic add(bit s, bit d, int len, input bit [23:0] tag);
        if (pend_v && pend.scl == s && pend.sda == d) begin
            pend.len = pend.len + len;
        end else begin
            if (pend_v) expq.push_back(pend);
            pend.scl = s; pend.sda = d; pend.len = len;
            pend.last = 0; pend.err = 0; pend.tag = tag;
            pend_v = 1;
        end
    endtask

    task automatic finish_run(bit e);
        pend.last = 1;
        pend.err = e;
        expq.push_back(pend);
        pend_v = 0;
    endtask

    task automatic exp_stop();
        add(1, 1, Q, "R4");
        add(0, 1, Q, "R4");
        add(0, 0, H + 1, "R4");
        finish_run(0);
    endtask

    task automatic exp_blind();
        for (int k = 0; k < NC; k++) begin
            add(0, 0, Q, "R2");
            add(0, 1, H, "R2");
            add(1, 1, Q, "R2");
            add(1, 0, Q, "R2");
            add(0, 0, Q, "R2");
            add(0, 1, Q, "R2");
            if (k < NC - 1) add(0, 1, G, "R3");
        end
        exp_stop();
    endtask

    task automatic exp_byte();
        add(1, 1, Q, "R7");
        for (int b = 0; b < NB; b++) begin
            add(1, 0, 2 * Q, "R7");
            add(0, 0, N + 1 + 2 * Q, "R7");
        end
        add(1, 0, Q, "R7");
        exp_stop();
    endtask

    // monitor side: measure runs of equal line state while busy
    bit cur_scl, cur_sda, run_v = 0;
    int run_len = 0;

    task automatic close_run(bit is_last, bit e_err);
        seg_t e;
        total++;
        if (expq.size() == 0) begin
            bad++;
            $display("FAIL R9: unexpected segment scl=%0d sda=%0d len=%0d actual=1 expected=0",
                     cur_scl, cur_sda, run_len);
        end else begin
            e = expq.pop_front();
            if (e.scl != cur_scl || e.sda != cur_sda || e.len != run_len ||
                e.last != is_last || (is_last && e.err != e_err)) begin
                bad++;
                $display("FAIL %s: segment scl/sda/len/end/err actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d",
                         e.tag, cur_scl, cur_sda, run_len, is_last, e_err,
                         e.scl, e.sda, e.len, e.last, e.err);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst && busy) begin
            if (!run_v) begin
                cur_scl = scl_pull; cur_sda = sda_pull; run_len = 1; run_v = 1;
            end else if (scl_pull != cur_scl || sda_pull != cur_sda) begin
                close_run(0, 0);
                cur_scl = scl_pull; cur_sda = sda_pull; run_len = 1;
            end else begin
                run_len++;
            end
            if (done) begin
                close_run(1, err);
                run_v = 0;
                done_cnt++;
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", wd, 100000);
            report();
        end
    end

    task automatic start_run(bit m);
        @(negedge clk);
        req = 1'b1; pmode = m;
        @(negedge clk);
        req = 1'b0; pmode = 1'b0;
    endtask

    task automatic wait_done(int n);
        do begin
            @(negedge clk);
            #1;
        end while (done_cnt < n);
    endtask

    task automatic check_drained(input bit [23:0] tag);
        check(expq.size() == 0 && !pend_v, tag, "expected segments left", expq.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        check({scl_pull, sda_pull, busy, done, err} == 5'b0, "R1", "outputs after reset",
              {scl_pull, sda_pull, busy, done, err}, 0);

        // R2 R3 R4: blind nine-frame run
        exp_blind();
        start_run(0);
        wait_done(1);
        check_drained("R2");
        repeat (3) @(negedge clk);
        check({scl_pull, sda_pull, busy} == 3'b0, "R1", "lines after run", {scl_pull, sda_pull, busy}, 0);

        // R9: requests during a run and during its done cycle are ignored
        exp_blind();
        start_run(0);
        repeat (200) @(negedge clk);
        req = 1'b1; pmode = 1'b1;
        @(negedge clk);
        req = 1'b0; pmode = 1'b0;
        wait_done(2);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(busy == 1'b0, "R9", "busy after request in done cycle", busy, 0);
            @(negedge clk);
        end
        check_drained("R9");

        // R5 R7: probe on a free bus
        repeat (5) @(negedge clk);
        add(0, 0, Q, "R5");
        add(0, 1, N + 1 + Q, "R5");
        exp_byte();
        start_run(1);
        wait_done(3);
        check_drained("R5");

        // R6: probe with SDA held low by the target
        stuck_base = scl_rises;
        stuck_len = 4;
        stuck_en = 1'b1;
        repeat (6) @(negedge clk);
        add(0, 0, Q, "R6");
        add(0, 1, 1 + Q, "R6");
        add(0, 0, Q, "R6");
        add(0, 1, 1 + Q, "R6");
        exp_byte();
        start_run(1);
        wait_done(4);
        check_drained("R6");
        check(sda_in == 1'b1, "R6", "SDA freed after recovery", sda_in, 1);
        stuck_en = 1'b0;

        // R8: SDA cannot be pulled low, busy wait expires
        sda_force_hi = 1'b1;
        repeat (6) @(negedge clk);
        add(0, 0, Q, "R8");
        add(0, 1, T, "R8");
        add(0, 0, 1, "R8");
        finish_run(1);
        start_run(1);
        wait_done(5);
        check_drained("R8");
        sda_force_hi = 1'b0;

        // R8: SCL held low, clock wait expires
        slv_scl_hold = 1'b1;
        repeat (6) @(negedge clk);
        add(0, 0, Q, "R8");
        add(0, 1, N + 1 + Q, "R8");
        add(1, 1, Q, "R8");
        add(1, 0, 2 * Q, "R8");
        add(0, 0, T + 1, "R8");
        finish_run(1);
        start_run(1);
        wait_done(6);
        check_drained("R8");
        slv_scl_hold = 1'b0;

        // R10: clean run after errors, no stale error flag
        repeat (6) @(negedge clk);
        add(0, 0, Q, "R10");
        add(0, 1, N + 1 + Q, "R10");
        exp_byte();
        start_run(1);
        wait_done(7);
        check_drained("R10");
        @(negedge clk);
        check({done, err} == 2'b0, "R10", "done/err after pulse", {done, err}, 0);

        report();
    end
endmodule